// File: doc/BRIEF.md
# Scan Test Pattern Sequencer

This block sits on the tester side of a single-chain scan design. It holds a small table of combinational test vectors and plays each one out, clock by clock, as a scan sequence. Every vector has four parts: a primary-input word, a present-state word that is loaded into the chain, an expected primary-output word and an expected next-state word. The block drives the chain's serial input, the test-control line and the primary inputs of the device under test. It checks the device's primary outputs and its serial chain output against the table, and it counts every mismatch.

Before the vectors run, the chain gets an integrity flush. A repeating two-zeros, two-ones pattern is shifted through the chain, so every cell sees both transitions, and the serial output is compared with the pattern as it was applied one chain length earlier. In the vector phase, the captured state of each vector is shifted out while the next vector's state is shifted in. One final unload follows the last capture. The run starts as soon as reset is released. It ends with a done flag, a sticky fail flag and a mismatch count.

Top module: `scan_pattern_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tc_o`=0, `scan_in_o`=0, `pi_o`=0, `done_o`=0, `fail_o`=0 and `mism_cnt_o`=0.
- R2: The flush phase lasts NS+4 cycles (7 with NS=3) with `tc_o`=0. In flush cycle t, `scan_in_o` is 1 when t mod 4 is 2 or 3, and 0 otherwise.
- R3: In flush cycles t >= NS, `scan_out_i` is compared with the flush bit of cycle t-NS. In the first NS flush cycles it is not compared.
- R4: Each vector k occupies NS shift cycles with `tc_o`=0, then one capture cycle with `tc_o`=1 and `pi_o`=PI(k). In shift cycle j (0-based), `scan_in_o` carries present-state bit NS-1-j, so the most significant bit is sent first. Cell i of the chain then holds bit i.
- R5: `pi_o` is 0 in every cycle where `tc_o` is 0.
- R6: `po_i` is compared with PO(k) only in the capture cycle of vector k. Its value in any other cycle has no effect.
- R7: In the shift cycles of vector k>0, `scan_out_i` in shift cycle j is compared with bit NS-1-j of NX(k-1). After the last capture come NS unload cycles with `tc_o`=0 and `scan_in_o`=0, which compare NX(NVEC-1) in the same bit order.
- R8: The vector phase lasts (NS+1)*NVEC+NS cycles. `done_o` rises in cycle NS+4+(NS+1)*NVEC+NS after reset (cycle 42 with the defaults) and stays high.
- R9: Each failed comparison adds 1 to `mism_cnt_o`. A failed comparison is one serial bit, or one whole primary-output word in a capture cycle. `fail_o` goes high with the first failed comparison and stays high until reset.
- R10: Table entry k holds PI(k)=k mod 2^NPI and PS(k)=(5k+3) mod 2^NS. NX(k) is PS(k) rotated left by one bit, XOR PI(k). PO(k) bit 0 is PI(k)[0] OR PS(k)[NS-1]. PO(k) bit 1 is the parity of PI(k) AND PS(k).
- R11: Once `done_o` is high, `tc_o` stays 0 and neither `scan_out_i` nor `po_i` affects the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the device under test |
| rst | input | 1 | Synchronous active-high reset; the run starts on release |
| scan_out_i | input | 1 | Serial output of the device's scan chain |
| po_i | input | NPO (2) | Primary outputs of the device |
| tc_o | output | 1 | Test control: 0 shifts the chain, 1 captures |
| scan_in_o | output | 1 | Serial input to the scan chain |
| pi_o | output | NPI (3) | Primary inputs to the device |
| done_o | output | 1 | Sequence finished |
| fail_o | output | 1 | Sticky: at least one comparison failed |
| mism_cnt_o | output | 6 | Number of failed comparisons |

## Verification
The bench models a three-cell chain with its own next-state and output logic. It walks the whole schedule cycle by cycle. Each timing corner maps to a visible failure. A sequencer that sends the state least significant bit first loads the wrong state and reports mismatches on a clean device. An off-by-one in the overlap of unload and load shifts the compared bits, and the count goes up. A length error moves the cycle in which done rises. Injected faults then go after the comparison rules. A corrupt output word must count exactly once, and so must one flipped captured bit. A stuck-at-0 serial line must count exactly the ones in the flush window and in the next-state words. Garbage on the outputs in shift cycles, in the unchecked flush cycles or after done must count nothing. A design that compares outside its windows shows up as a nonzero count.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int NS        = 3;
    localparam int NPI       = 3;
    localparam int NPO       = 2;
    localparam int NVEC_MAX  = 8;
    localparam int FLUSH_LEN = NS + 4;
    localparam int SW        = $clog2(NS);

    typedef logic [NS-1:0]  state_t;
    typedef logic [NPI-1:0] pin_t;
    typedef logic [NPO-1:0] pout_t;

    typedef struct packed {
        pin_t   pi;
        state_t ps;
        pout_t  po;
        state_t nx;
    } vec_t;

    typedef struct packed {
        logic  so_en;
        logic  so_exp;
        logic  po_en;
        pout_t po_exp;
    } chk_t;

    typedef enum logic [2:0] {
        PH_FLUSH,
        PH_SHIFT,
        PH_CAPT,
        PH_UNLOAD,
        PH_DONE
    } phase_t;

    // Flush bit for cycle t: 0,0,1,1 repeating.
    function automatic logic flush_bit(input int unsigned t);
        return (t % 4) >= 2;
    endfunction

    // Table entry k: stimulus and the expected device response.
    function automatic vec_t make_vec(input int unsigned k);
        vec_t   v;
        state_t rot;
        state_t pi_ext;
        v.pi   = pin_t'(k);
        v.ps   = state_t'(5 * k + 3);
        pi_ext = state_t'(v.pi);
        rot    = {v.ps[NS-2:0], v.ps[NS-1]};
        v.nx   = rot ^ pi_ext;
        v.po    = '0;
        v.po[0] = v.pi[0] | v.ps[NS-1];
        v.po[1] = ^(pi_ext & v.ps);
        return v;
    endfunction

endpackage

// File: rtl/scan_seq_rom.sv
module scan_seq_rom
    import scan_seq_pkg::*;
#(
    parameter int NVEC = 8,
    localparam int IW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic [IW-1:0] idx_a,
    input  logic [IW-1:0] idx_b,
    output vec_t          vec_a,
    output vec_t          vec_b
);

    vec_t tbl [NVEC];

    for (genvar g = 0; g < NVEC; g++) begin : g_ent
        assign tbl[g] = make_vec(g);
    end

    assign vec_a = tbl[idx_a];
    assign vec_b = tbl[idx_b];

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int NVEC = 8,
    localparam int IW  = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int CW  = $clog2(FLUSH_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output phase_t        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic [IW-1:0] vidx_o
);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [IW-1:0] vidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FLUSH;
            cnt   <= '0;
            vidx  <= '0;
        end else begin
            case (phase)
                PH_FLUSH: begin
                    if (cnt == CW'(FLUSH_LEN - 1)) begin
                        phase <= PH_SHIFT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == CW'(NS - 1)) begin
                        phase <= PH_CAPT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CAPT: begin
                    cnt <= '0;
                    if (vidx == IW'(NVEC - 1)) begin
                        phase <= PH_UNLOAD;
                    end else begin
                        phase <= PH_SHIFT;
                        vidx  <= vidx + 1'b1;
                    end
                end
                PH_UNLOAD: begin
                    if (cnt == CW'(NS - 1)) begin
                        phase <= PH_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_DONE;
                end
            endcase
        end
    end

    assign phase_o = phase;
    assign cnt_o   = cnt;
    assign vidx_o  = vidx;

endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp
    import scan_seq_pkg::*;
#(
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  chk_t          chk,
    input  logic          so_i,
    input  pout_t         po_i,
    output logic          fail_o,
    output logic [MW-1:0] cnt_o
);

    logic          miss;
    logic          fail_q;
    logic [MW-1:0] cnt_q;

    always_comb begin
        miss = 1'b0;
        if (chk.so_en && (so_i != chk.so_exp)) miss = 1'b1;
        if (chk.po_en && (po_i != chk.po_exp)) miss = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
            cnt_q  <= '0;
        end else if (miss) begin
            fail_q <= 1'b1;
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fail_o = fail_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/scan_pattern_seq.sv
module scan_pattern_seq
    import scan_seq_pkg::*;
#(
    parameter int NVEC    = 8,
    localparam int IW     = (NVEC > 1) ? $clog2(NVEC) : 1,
    localparam int CW     = $clog2(FLUSH_LEN),
    localparam int MAX_EV = (FLUSH_LEN - NS) + NVEC * (NS + 1),
    localparam int MW     = $clog2(MAX_EV + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           scan_out_i,
    input  logic [NPO-1:0] po_i,
    output logic           tc_o,
    output logic           scan_in_o,
    output logic [NPI-1:0] pi_o,
    output logic           done_o,
    output logic           fail_o,
    output logic [MW-1:0]  mism_cnt_o
);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [IW-1:0] vidx;
    logic [IW-1:0] vprev;
    vec_t          cur;
    vec_t          prv;
    chk_t          chk;
    logic [SW-1:0] bsel;

    scan_seq_ctrl #(.NVEC(NVEC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase),
        .cnt_o   (cnt),
        .vidx_o  (vidx)
    );

    assign vprev = vidx - 1'b1;

    scan_seq_rom #(.NVEC(NVEC)) u_rom (
        .idx_a (vidx),
        .idx_b (vprev),
        .vec_a (cur),
        .vec_b (prv)
    );

    // Chain bit order: most significant state bit travels first.
    assign bsel = SW'(NS - 1 - int'(cnt));

    always_comb begin
        tc_o      = 1'b0;
        scan_in_o = 1'b0;
        pi_o      = '0;
        done_o    = 1'b0;
        chk       = '0;
        case (phase)
            PH_FLUSH: begin
                scan_in_o = flush_bit(int'(cnt));
                if (int'(cnt) >= NS) begin
                    chk.so_en  = 1'b1;
                    chk.so_exp = flush_bit(int'(cnt) - NS);
                end
            end
            PH_SHIFT: begin
                scan_in_o = cur.ps[bsel];
                if (vidx != '0) begin
                    chk.so_en  = 1'b1;
                    chk.so_exp = prv.nx[bsel];
                end
            end
            PH_CAPT: begin
                tc_o       = 1'b1;
                pi_o       = cur.pi;
                chk.po_en  = 1'b1;
                chk.po_exp = cur.po;
            end
            PH_UNLOAD: begin
                chk.so_en  = 1'b1;
                chk.so_exp = cur.nx[bsel];
            end
            default: begin
                done_o = 1'b1;
            end
        endcase
    end

    scan_seq_cmp #(.MW(MW)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .chk    (chk),
        .so_i   (scan_out_i),
        .po_i   (po_i),
        .fail_o (fail_o),
        .cnt_o  (mism_cnt_o)
    );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk
    import scan_seq_pkg::*;
#(
    parameter int MW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           tc_o,
    input logic [NPI-1:0] pi_o,
    input logic           done_o,
    input logic           fail_o,
    input logic [MW-1:0]  mism_cnt_o
);

    a_r5_pi_quiet_in_shift: assert property (@(posedge clk) disable iff (rst)
        !tc_o |-> pi_o == '0);

    a_r4_single_capture: assert property (@(posedge clk) disable iff (rst)
        tc_o |=> !tc_o);

    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);

    a_r9_count_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (mism_cnt_o == $past(mism_cnt_o)) ||
                 (mism_cnt_o == $past(mism_cnt_o) + 1'b1));

    a_r11_done_holds_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o && !tc_o && $stable(mism_cnt_o));

endmodule

bind scan_pattern_seq scan_seq_chk #(.MW(MW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tc_o       (tc_o),
    .pi_o       (pi_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .mism_cnt_o (mism_cnt_o)
);

// File: tb/scan_pattern_seq_bench.sv
`timescale 1ns/1ps
module scan_pattern_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_out_i;
    logic [1:0] po_i;
    logic       tc_o;
    logic       scan_in_o;
    logic [2:0] pi_o;
    logic       done_o;
    logic       fail_o;
    logic [5:0] mism_cnt_o;

    int n_chk  = 0;
    int n_fail = 0;
    int mode   = 0;
    int cyc    = 0;
    logic [2:0] chain = 3'b000;

    always #5 clk = ~clk;

    scan_pattern_seq u_scan_pattern_seq (
        .clk        (clk),
        .rst        (rst),
        .scan_out_i (scan_out_i),
        .po_i       (po_i),
        .tc_o       (tc_o),
        .scan_in_o  (scan_in_o),
        .pi_o       (pi_o),
        .done_o     (done_o),
        .fail_o     (fail_o),
        .mism_cnt_o (mism_cnt_o)
    );

    // Device model: next state and outputs from the R10 formulas.
    function automatic int dev_nx(input int pi, input int st);
        return (((st << 1) | (st >> 2)) & 7) ^ (pi & 7);
    endfunction

    function automatic int dev_po(input int pi, input int st);
        int par;
        par = $countones(3'(pi & st)) % 2;
        return par * 2 + ((pi & 1) | ((st >> 2) & 1));
    endfunction

    function automatic int b_ps(input int k);
        return (5 * k + 3) % 8;
    endfunction

    function automatic int b_nx(input int k);
        return dev_nx(k % 8, b_ps(k));
    endfunction

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        if (!tc_o) begin
            chain <= {chain[1:0], scan_in_o};
        end else begin
            // mode 2 corrupts one captured bit of vector 2
            chain <= 3'(dev_nx(int'(pi_o), int'(chain))) ^
                     ((mode == 2 && cyc == 18) ? 3'b010 : 3'b000);
        end
    end

    always_comb begin
        if (mode == 3) scan_out_i = 1'b0;
        else scan_out_i = chain[2] ^ ((mode == 4) && (done_o || cyc < 3));
        po_i = 2'(dev_po(int'(pi_o), int'(chain)));
        if (mode == 1 && cyc == 30) po_i = po_i ^ 2'b01;
        if (mode == 4 && !tc_o)     po_i = po_i ^ 2'b11;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (mode %0d, cycle %0d)",
                     req, act, exp, mode, cyc);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tc_o == 0 && scan_in_o == 0 && pi_o == 0, "R1 outputs in reset",
              {tc_o, scan_in_o, pi_o}, 0);
        check(done_o == 0 && fail_o == 0 && mism_cnt_o == 0, "R1 status in reset",
              {done_o, fail_o, mism_cnt_o}, 0);
        rst = 1'b0;
    endtask

    // Expected tc/si/pi at cycle t (R2, R4, R5, R7).
    task automatic check_sched(input int t);
        int etc, esi, epi, u, k, j;
        bit chk_si;
        etc = 0; esi = 0; epi = 0; chk_si = 1;
        if (t < 7) begin
            esi = ((t % 4) >= 2) ? 1 : 0;
        end else if (t < 39) begin
            u = t - 7; k = u / 4; j = u % 4;
            if (j < 3) esi = (b_ps(k) >> (2 - j)) & 1;
            else begin etc = 1; epi = k; chk_si = 0; end
        end
        if (t < 7) check(tc_o == etc && scan_in_o == esi, "R2 flush drive",
                         {tc_o, scan_in_o}, {etc[0], esi[0]});
        else if (t < 39) begin
            check(tc_o == etc, "R4 test control", tc_o, etc);
            if (chk_si) check(scan_in_o == esi, "R4 state bit order", scan_in_o, esi);
            else check(pi_o == epi, "R4 capture inputs", pi_o, epi);
        end else begin
            check(tc_o == 0 && scan_in_o == 0, "R7 unload drive", {tc_o, scan_in_o}, 0);
        end
        if (etc == 0) check(pi_o == 0, "R5 inputs quiet in shift", pi_o, 0);
        check(done_o == (t >= 42), "R8 done timing", done_o, t >= 42);
    endtask

    task automatic run_case(input int m, input int exp_cnt);
        mode = m;
        do_reset();
        for (int t = 0; t < 45; t++) begin
            if (m == 0) check_sched(t);
            @(negedge clk);
        end
        check(done_o == 1, "R8 done held", done_o, 1);
        check(mism_cnt_o == exp_cnt, "R9 mismatch count", mism_cnt_o, exp_cnt);
        check(fail_o == (exp_cnt != 0), "R9 sticky fail", fail_o, exp_cnt != 0);
    endtask

    initial begin
        int stuck;
        // R3/R7 stuck-at-0 serial line: flush window gives p(0..3)=0,0,1,1
        stuck = 2;
        for (int k = 0; k < 8; k++) stuck += $countones(3'(b_nx(k)));
        run_case(0, 0);      // R10 table matches the device: clean run
        run_case(1, 1);      // R6 one bad output word in capture of vector 5
        run_case(2, 1);      // R7 one bad captured bit unloaded during overlap
        run_case(3, stuck);  // R3 R7 stuck serial output
        run_case(4, 0);      // R6 R11 R3 garbage outside compare windows ignored
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule